// File: doc/BRIEF.md
# Atomic Scratch Register Bank

A small bank of five scratch registers sits behind a simple register port (byte offset, write enable, write data, read enable). Software uses it for general storage and for lock and semaphore primitives. Each register answers at two offsets. At the plain offset it behaves as ordinary storage. At the alias offset, which is 0x40 above the plain one, an atomic conditional action applies.

Registers 0 to 2 are 64 bits wide. At their alias offsets a write lands only when the register currently holds zero, so a lock can be claimed by writing an owner tag. Registers 3 and 4 are single flags held in bit 0. At their alias offsets a read returns the flag and leaves it set, which is a test-and-set. The test and the update finish in the same clock cycle, so accesses issued back to back take effect in order. Read data is registered and is returned one cycle after the read with a valid strobe.

Top module: `scratch_bank`

## Requirements
- R1: After reset, registers 0, 3 and 4 read as zero and rd_valid is low. Registers 1 and 2 keep whatever value they held before reset.
- R2: Registers 0, 1 and 2 sit at offsets 0x00, 0x08 and 0x10. A write there stores all 64 bits of wr_data, and a read there returns the stored value.
- R3: At offsets 0x40, 0x48 and 0x50, a write to register 0, 1 or 2 is stored only if that register currently holds zero. Otherwise the write is discarded.
- R4: A read at offsets 0x40, 0x48 or 0x50 returns the register's current value and changes nothing.
- R5: Registers 3 and 4 sit at offsets 0x18 and 0x20. A write stores wr_data bit 0. A read returns the flag in bit 0, with bits 63:1 reading as zero.
- R6: A read at offset 0x58 (register 3) or 0x60 (register 4) returns the flag's current value and leaves the flag at 1.
- R7: A write at offset 0x58 or 0x60 stores wr_data bit 0 into the flag, exactly as a plain write does.
- R8: rd_valid is high in the cycle after an edge that sampled rd_en high with wr_en low, and low otherwise. rd_data is zero whenever rd_valid is low.
- R9: Any other offset, including misaligned ones, returns zero data with rd_valid on a read and leaves every register unchanged on a write.
- R10: When wr_en and rd_en are both high on the same edge, only the write is performed. No read response follows and no read side effect happens.
- R11: An access sees the result of the access at the edge before it. Two back-to-back test-and-set reads of a clear flag return 0 and then 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every transfer is sampled on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 7 | Byte offset of the access within the bank |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write value |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 64 | Registered read value; zero when no response |
| rd_valid | output | 1 | High for one cycle carrying a read response |

## Verification
Every register update, including a test-and-set side effect or a conditional write, is visible at the first edge after the access. The read response for an access sampled at edge k appears just after edge k. The bench applies one access per cycle, waits for the capturing edge, and then samples rd_valid and rd_data a short delay later. It compares them with values from a reference model that is updated in request order, so back-to-back accesses are checked with no idle cycles between them.

// File: rtl/scratch_bank_pkg.sv
package scratch_bank_pkg;

    // Default geometry of the bank
    localparam int unsigned WORD_W    = 64;
    localparam int unsigned OFS_W     = 7;
    localparam int unsigned WIDE_CNT  = 3;
    localparam int unsigned FLAG_CNT  = 2;
    localparam int unsigned SLOT_B    = 8;
    localparam int unsigned ALIAS_B   = 64;

    // Kind of transfer presented on the port in a cycle
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } acc_e;

endpackage

// File: rtl/sb_decode.sv
module sb_decode #(
    parameter int unsigned ADDR_W    = 7,
    parameter int unsigned N_REGS    = 5,
    parameter int unsigned STRIDE_B  = 8,
    parameter int unsigned ALIAS_OFS = 64
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_REGS-1:0] hit_plain,
    output logic [N_REGS-1:0] hit_alias
);

    // Exact match only: misaligned or out-of-range offsets hit nothing
    always_comb begin
        hit_plain = '0;
        hit_alias = '0;
        for (int i = 0; i < N_REGS; i++) begin
            hit_plain[i] = (addr == ADDR_W'(i * STRIDE_B));
            hit_alias[i] = (addr == ADDR_W'(ALIAS_OFS + i * STRIDE_B));
        end
    end

endmodule

// File: rtl/sb_wide_cell.sv
module sb_wide_cell #(
    parameter int unsigned W        = 64,
    parameter bit          RESET_EN = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_plain,
    input  logic         wr_ifzero,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value
);

    logic [W-1:0] value_d;
    logic [W-1:0] value_q;

    // Conditional test and update resolve in the same cycle
    always_comb begin
        value_d = value_q;
        if (wr_plain) begin
            value_d = wdata;
        end else if (wr_ifzero && (value_q == '0)) begin
            value_d = wdata;
        end
    end

    generate
        if (RESET_EN) begin : g_rst
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) value_q <= '0;
                else        value_q <= value_d;
            end
        end else begin : g_norst
            always_ff @(posedge clk) begin
                value_q <= value_d;
            end
        end
    endgenerate

    assign value = value_q;

    // R3
    wz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ifzero && !wr_plain && (value_q != '0)) |=> $stable(value_q));

    // R3
    wz_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ifzero && (value_q == '0)) |=> (value_q == $past(wdata)));

    // R2
    plain_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_plain |=> (value_q == $past(wdata)));

endmodule

// File: rtl/sb_flag_cell.sv
module sb_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic rs_rd,
    output logic flag
);

    logic flag_d;
    logic flag_q;

    always_comb begin
        flag_d = flag_q;
        if (wr_en) begin
            flag_d = wr_bit;
        end else if (rs_rd && !flag_q) begin
            flag_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

    // R6
    rs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_rd && !wr_en) |=> flag_q);

    // R7
    flag_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (flag_q == $past(wr_bit)));

endmodule

// File: rtl/scratch_bank.sv
module scratch_bank
    import scratch_bank_pkg::*;
#(
    parameter int unsigned DATA_W    = WORD_W,
    parameter int unsigned ADDR_W    = OFS_W,
    parameter int unsigned N_WIDE    = WIDE_CNT,
    parameter int unsigned N_FLAG    = FLAG_CNT,
    parameter int unsigned STRIDE_B  = SLOT_B,
    parameter int unsigned ALIAS_OFS = ALIAS_B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    localparam int unsigned N_REGS = N_WIDE + N_FLAG;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rsp_t;

    acc_e              acc;
    logic              is_wr;
    logic              is_rd;
    logic [N_REGS-1:0] hit_plain;
    logic [N_REGS-1:0] hit_alias;
    logic              hit_any;
    logic [DATA_W-1:0] wide_val [N_WIDE];
    logic [N_FLAG-1:0] flag_val;
    logic [DATA_W-1:0] rd_word;
    rsp_t              rsp_d;
    rsp_t              rsp_q;

    // Write wins when both strobes are raised together
    always_comb begin
        if (wr_en)      acc = ACC_WRITE;
        else if (rd_en) acc = ACC_READ;
        else            acc = ACC_IDLE;
    end

    assign is_wr = (acc == ACC_WRITE);
    assign is_rd = (acc == ACC_READ);

    sb_decode #(
        .ADDR_W    (ADDR_W),
        .N_REGS    (N_REGS),
        .STRIDE_B  (STRIDE_B),
        .ALIAS_OFS (ALIAS_OFS)
    ) u_decode (
        .addr      (addr),
        .hit_plain (hit_plain),
        .hit_alias (hit_alias)
    );

    assign hit_any = |{hit_plain, hit_alias};

    // Wide registers: only the first one is cleared by reset
    generate
        for (genvar i = 0; i < N_WIDE; i++) begin : g_wide
            sb_wide_cell #(
                .W        (DATA_W),
                .RESET_EN (i == 0)
            ) u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_plain  (is_wr && hit_plain[i]),
                .wr_ifzero (is_wr && hit_alias[i]),
                .wdata     (wr_data),
                .value     (wide_val[i])
            );
        end

        for (genvar j = 0; j < N_FLAG; j++) begin : g_flag
            sb_flag_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (is_wr && (hit_plain[N_WIDE+j] || hit_alias[N_WIDE+j])),
                .wr_bit (wr_data[0]),
                .rs_rd  (is_rd && hit_alias[N_WIDE+j]),
                .flag   (flag_val[j])
            );
        end
    endgenerate

    // Read mux samples the values before this cycle's update
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < N_WIDE; i++) begin
            if (hit_plain[i] || hit_alias[i]) rd_word = wide_val[i];
        end
        for (int j = 0; j < N_FLAG; j++) begin
            if (hit_plain[N_WIDE+j] || hit_alias[N_WIDE+j]) begin
                rd_word = {{(DATA_W-1){1'b0}}, flag_val[j]};
            end
        end
    end

    always_comb begin
        rsp_d.valid = is_rd;
        rsp_d.data  = is_rd ? rd_word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rd_data  = rsp_q.data;
    assign rd_valid = rsp_q.valid;

    // R8
    rsp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en && !wr_en));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !hit_any) |=> (rd_valid && (rd_data == '0)));

    // R10
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en) |=> !rd_valid);

endmodule

// File: tb/scratch_bank_test.sv
`timescale 1ns/1ps
module scratch_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [63:0] rd_data;
    logic        rd_valid;

    int unsigned n_vec  = 0;
    int unsigned n_fail = 0;
    bit          done   = 1'b0;

    logic [63:0] m_wide [3];
    logic        m_flag [2];

    always #5 clk = ~clk;

    scratch_bank uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // Offset map from the requirements: plain 8*i, alias 0x40+8*i
    function automatic int reg_of(input logic [6:0] a, output bit al);
        int idx = -1;
        al = 1'b0;
        for (int i = 0; i < 5; i++) begin
            if (a == 7'(8 * i)) idx = i;
            if (a == 7'(64 + 8 * i)) begin idx = i; al = 1'b1; end
        end
        return idx;
    endfunction

    function automatic string tag_for(input bit w, input bit r, input logic [6:0] a);
        bit al;
        int idx = reg_of(a, al);
        if (w && r)   return "R10";
        if (idx < 0)  return "R9";
        if (idx < 3)  return al ? (w ? "R3" : "R4") : "R2";
        if (al)       return w ? "R7" : "R6";
        return "R5";
    endfunction

    task automatic check(input string tag, input logic v, input logic [63:0] d,
                         input logic ev, input logic [63:0] ed);
        n_vec++;
        if (v !== ev || d !== ed) begin
            n_fail++;
            $display("FAIL %s: rd_valid=%0b rd_data=%h expected rd_valid=%0b rd_data=%h",
                     tag, v, d, ev, ed);
        end
    endtask

    // One access per cycle; model updated in request order
    task automatic access(input bit w, input bit r, input logic [6:0] a,
                          input logic [63:0] d, input string tag);
        bit          al;
        int          idx = reg_of(a, al);
        logic        ev = r && !w;
        logic [63:0] ed = '0;
        if (ev && idx >= 0) begin
            if (idx < 3) ed = m_wide[idx];
            else         ed = {63'd0, m_flag[idx-3]};
        end
        if (ev && idx >= 3 && al) m_flag[idx-3] = 1'b1;
        if (w && idx >= 0) begin
            if (idx < 3) begin
                if (!al || m_wide[idx] == 64'd0) m_wide[idx] = d;
            end else begin
                m_flag[idx-3] = d[0];
            end
        end
        addr = a; wr_en = w; rd_en = r; wr_data = d;
        @(posedge clk);
        #2;
        wr_en = 1'b0; rd_en = 1'b0;
        check(tag, rd_valid, rd_data, ev, ed);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_wide[0] = '0; m_wide[1] = '0; m_wide[2] = '0;
        m_flag[0] = 1'b0; m_flag[1] = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        check("R1", rd_valid, rd_data, 1'b0, 64'd0);

        // R1 reset values
        access(0, 1, 7'h00, 64'd0, "R1");
        access(0, 1, 7'h18, 64'd0, "R1");
        access(0, 1, 7'h20, 64'd0, "R1");

        // R2 plain storage (also defines registers 1 and 2)
        access(1, 0, 7'h00, 64'hA5A5_5A5A_0123_4567, "R2");
        access(0, 1, 7'h00, 64'd0, "R2");
        access(1, 0, 7'h08, 64'h1111_2222_3333_4444, "R2");
        access(0, 1, 7'h08, 64'd0, "R2");
        access(1, 0, 7'h10, 64'hFFFF_0000_FFFF_0000, "R2");
        access(0, 1, 7'h10, 64'd0, "R2");

        // R3 write-if-zero: rejected while nonzero, accepted at zero
        access(1, 0, 7'h40, 64'hDEAD_BEEF_0000_0001, "R3");
        access(0, 1, 7'h00, 64'd0, "R3");
        access(1, 0, 7'h00, 64'd0, "R3");
        access(1, 0, 7'h40, 64'hDEAD_BEEF_0000_0001, "R3");
        access(0, 1, 7'h00, 64'd0, "R3");
        access(1, 0, 7'h40, 64'h0000_0000_0000_0002, "R3");
        access(0, 1, 7'h00, 64'd0, "R3");

        // R4 alias read has no side effect
        access(0, 1, 7'h48, 64'd0, "R4");
        access(0, 1, 7'h08, 64'd0, "R4");

        // R5 flag storage in bit 0 only
        access(1, 0, 7'h18, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
        access(0, 1, 7'h18, 64'd0, "R5");
        access(1, 0, 7'h18, 64'hFFFF_FFFF_FFFF_FFFE, "R5");
        access(0, 1, 7'h18, 64'd0, "R5");

        // R6 / R11 back-to-back test-and-set
        access(0, 1, 7'h58, 64'd0, "R6");
        access(0, 1, 7'h58, 64'd0, "R11");
        access(0, 1, 7'h18, 64'd0, "R6");

        // R7 alias writes are plain flag writes
        access(1, 0, 7'h58, 64'd0, "R7");
        access(0, 1, 7'h18, 64'd0, "R7");
        access(1, 0, 7'h60, 64'd1, "R7");
        access(0, 1, 7'h20, 64'd0, "R7");

        // R9 unmapped and misaligned offsets
        access(1, 0, 7'h28, 64'h5555_5555_5555_5555, "R9");
        access(1, 0, 7'h04, 64'h0, "R9");
        access(1, 0, 7'h7C, 64'h1, "R9");
        access(0, 1, 7'h28, 64'd0, "R9");
        access(0, 1, 7'h7C, 64'd0, "R9");
        for (int i = 0; i < 5; i++) access(0, 1, 7'(8 * i), 64'd0, "R9");

        // R10 write wins over simultaneous read, no test-and-set
        access(1, 1, 7'h10, 64'h0BAD_F00D_0000_0000, "R10");
        access(0, 1, 7'h10, 64'd0, "R10");
        access(1, 0, 7'h20, 64'd0, "R10");
        access(1, 1, 7'h60, 64'd0, "R10");
        access(0, 1, 7'h20, 64'd0, "R10");

        // R8 idle cycle
        access(0, 0, 7'h00, 64'd0, "R8");

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic [6:0]  a;
            logic [63:0] d;
            bit          w;
            bit          r;
            int unsigned pick = $urandom_range(0, 11);
            if (pick < 5)       a = 7'(8 * pick);
            else if (pick < 10) a = 7'(64 + 8 * (pick - 5));
            else                a = 7'($urandom_range(0, 127));
            case ($urandom_range(0, 2))
                0:       d = 64'd0;
                1:       d = 64'($urandom_range(0, 3));
                default: d = {$urandom, $urandom};
            endcase
            w = ($urandom_range(0, 2) == 0);
            r = ($urandom_range(0, 9) < 6);
            access(w, r, a, d, tag_for(w, r, a));
        end

        done = 1'b1;
        finish_run();
    end

endmodule